// File: doc/BRIEF.md
# Host Bus Write Snooper for Screen Shadowing

This block sits beside a byte-wide host bus with a 20-bit address, an active-low read/write line and an active-low data strobe. It only listens. It never drives the bus, never returns an acknowledge and never asks for mastership, so the host's cycles are not stretched. Whenever the host writes into a selectable shadow window, the block queues an entry that holds the byte and its offset inside the window. A slower companion processor can then rebuild the screen image from that stream.

The window is 32 KB by default, which matches the host's screen memory. It can be widened to 64 KB or 128 KB. The window base comes from a configuration input and is aligned to the chosen size. The strobe and read/write lines are synchronized into the local clock. Each synchronized falling edge of the strobe, seen while the cycle is a write, samples the address and data once. The drain side reads the queue through a first-word-fall-through ready/valid port, and it can see how many entries are waiting so that it can read in bursts. When the queue is full, further hits are dropped and a sticky overflow flag is raised until a clear pulse arrives.

Top module: `bus_write_snooper`

## Requirements
- R1: After reset, fifoCount is 0, rdValid is 0 and overflow is 0.
- R2: A host write (hostRwN low during the strobe) inside the window adds exactly one entry per strobe-low period, however long the strobe stays low.
- R3: A host read (hostRwN high during the strobe) adds no entry.
- R4: cfgSize 0 selects a 32 KB window (hostAddr[19:15] must equal cfgBase[4:0]). cfgSize 1 selects 64 KB (bits 19:16 against cfgBase[4:1]). cfgSize 2 or 3 selects 128 KB (bits 19:17 against cfgBase[4:2]). Base bits below the window size are ignored.
- R5: Each entry holds the offset, which is the address bits below the window size zero-extended to 17 bits, and the data byte of that write.
- R6: Entries leave in arrival order. rdOffset and rdData show the oldest entry while rdValid is high. rdValid is high exactly when fifoCount is nonzero. One entry is removed on each clock edge where rdValid and rdReady are both high.
- R7: A window write that arrives while fifoCount equals the depth (16) is dropped, leaves the stored entries unchanged, and sets overflow. overflow stays set until it is cleared.
- R8: A high ovfClr clears overflow at the next edge. If a dropped write falls in the same cycle, the set wins.
- R9: A capture and a read in the same cycle leave fifoCount unchanged and remove the old head.
- R10: fifoCount always equals the number of stored entries and never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Snooper clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 20 | Observed host address |
| hostData | input | 8 | Observed host data byte |
| hostRwN | input | 1 | Host read/write, low for write |
| hostDsN | input | 1 | Host data strobe, active low |
| cfgBase | input | 5 | Window base, address bits 19:15 |
| cfgSize | input | 2 | Window size code (0: 32 KB, 1: 64 KB, 2/3: 128 KB) |
| ovfClr | input | 1 | Pulse that clears the overflow flag |
| rdReady | input | 1 | Drain side accepts the head entry |
| rdValid | output | 1 | Queue holds at least one entry |
| rdOffset | output | 17 | Window offset of the head entry |
| rdData | output | 8 | Data byte of the head entry |
| fifoCount | output | 5 | Number of stored entries |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
Two pairs of events can land in the same clock cycle: a capture together with a drain read, and a dropped write together with an overflow clear. The bench works out the exact cycle in which the synchronized strobe edge is seen. In that cycle it raises rdReady, or ovfClr with the queue full. It then judges the result: the count is unchanged and the popped head matches, and for the second pair overflow remains set. Random window sizes, bases, addresses and read/write mixes are checked against a queue model that the bench keeps itself.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  // Strobes from the control section to the queue datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobes_t;
endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter bit [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stageQ[s] <= RESET_VAL;
      else if (s == 0) stageQ[s] <= asyncIn;
      else stageQ[s] <= stageQ[(s == 0) ? 0 : s - 1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter int SIZE_W = 2,
  parameter int SIZE_STEPS = 3,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SEL_SPAN = 1 << SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsSyncN,
  input  logic              rwSyncN,
  input  logic [TAG_W-1:0]  addrTag,
  input  logic [TAG_W-1:0]  baseTag,
  input  logic [SIZE_W-1:0] cfgSize,
  input  logic              ovfClr,
  input  logic              rdReady,
  input  logic [CNT_W-1:0]  fifoCount,
  output fifoStrobes_t      ctl,
  output logic              overflow
);
  logic dsPrevN;
  logic strobeFall;
  logic writeSeen;
  logic inWindow;
  logic queueFull;
  logic capture;
  logic dropNow;
  logic [SEL_SPAN-1:0] hitBySize;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dsPrevN <= 1'b1;
    else dsPrevN <= dsSyncN;
  end

  assign strobeFall = dsPrevN & ~dsSyncN;
  assign writeSeen  = strobeFall & ~rwSyncN;

  // One comparator per size code; codes past the largest size reuse it
  for (genvar k = 0; k < SEL_SPAN; k++) begin : g_win
    localparam int DROP = (k < SIZE_STEPS) ? k : SIZE_STEPS - 1;
    assign hitBySize[k] = ((addrTag >> DROP) == (baseTag >> DROP));
  end

  assign inWindow  = hitBySize[cfgSize];
  assign queueFull = (fifoCount == CNT_W'(DEPTH));
  assign capture   = writeSeen & inWindow;
  assign dropNow   = capture & queueFull;

  always_comb begin
    ctl.push = capture & ~queueFull;
    ctl.pop  = rdReady & (fifoCount != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else if (dropNow) overflow <= 1'b1;
    else if (ovfClr) overflow <= 1'b0;
  end
endmodule

// File: rtl/snoop_datapath.sv
module snoop_datapath
  import snoop_pkg::*;
#(
  parameter int MIN_WIN_BITS = 15,
  parameter int SIZE_W = 2,
  parameter int SIZE_STEPS = 3,
  parameter int DATA_W = 8,
  parameter int DEPTH = 16,
  localparam int OFF_W = MIN_WIN_BITS + SIZE_STEPS - 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ENTRY_W = OFF_W + DATA_W,
  localparam int SEL_SPAN = 1 << SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoStrobes_t      ctl,
  input  logic [OFF_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] hostData,
  input  logic [SIZE_W-1:0] cfgSize,
  output logic              rdValid,
  output logic [OFF_W-1:0]  rdOffset,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  fifoCount
);
  logic [OFF_W-1:0]   offMask [SEL_SPAN];
  logic [OFF_W-1:0]   winOffset;
  logic [ENTRY_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic [CNT_W-1:0]   count;

  for (genvar k = 0; k < SEL_SPAN; k++) begin : g_mask
    localparam int WB = MIN_WIN_BITS + ((k < SIZE_STEPS) ? k : SIZE_STEPS - 1);
    assign offMask[k] = ~({OFF_W{1'b1}} << WB);
  end

  assign winOffset = addrLow & offMask[cfgSize];

  always_ff @(posedge clk) begin
    if (ctl.push) store[wrPtr] <= {winOffset, hostData};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + 1'b1;
      if (ctl.pop) rdPtr <= rdPtr + 1'b1;
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdValid   = (count != '0);
  assign {rdOffset, rdData} = store[rdPtr];
  assign fifoCount = count;
endmodule

// File: rtl/bus_write_snooper.sv
module bus_write_snooper
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int MIN_WIN_BITS = 15,
  parameter int SIZE_STEPS = 3,
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SIZE_W = $clog2(SIZE_STEPS),
  localparam int TAG_W = ADDR_W - MIN_WIN_BITS,
  localparam int OFF_W = MIN_WIN_BITS + SIZE_STEPS - 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostRwN,
  input  logic              hostDsN,
  input  logic [TAG_W-1:0]  cfgBase,
  input  logic [SIZE_W-1:0] cfgSize,
  input  logic              ovfClr,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [OFF_W-1:0]  rdOffset,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              overflow
);
  logic [1:0]   busSync;
  fifoStrobes_t ctl;

  snoop_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({hostDsN, hostRwN}),
    .syncOut(busSync)
  );

  snoop_ctrl #(
    .TAG_W(TAG_W), .SIZE_W(SIZE_W), .SIZE_STEPS(SIZE_STEPS), .DEPTH(DEPTH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dsSyncN(busSync[1]), .rwSyncN(busSync[0]),
    .addrTag(hostAddr[ADDR_W-1:MIN_WIN_BITS]),
    .baseTag(cfgBase), .cfgSize(cfgSize),
    .ovfClr(ovfClr), .rdReady(rdReady),
    .fifoCount(fifoCount), .ctl(ctl), .overflow(overflow)
  );

  snoop_datapath #(
    .MIN_WIN_BITS(MIN_WIN_BITS), .SIZE_W(SIZE_W), .SIZE_STEPS(SIZE_STEPS),
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .addrLow(hostAddr[OFF_W-1:0]), .hostData(hostData), .cfgSize(cfgSize),
    .rdValid(rdValid), .rdOffset(rdOffset), .rdData(rdData),
    .fifoCount(fifoCount)
  );
endmodule

// File: rtl/snoop_checker.sv
module snoop_checker #(
  parameter int DEPTH = 16,
  parameter int OFF_W = 17,
  parameter int DATA_W = 8,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ovfClr,
  input logic              rdReady,
  input logic              rdValid,
  input logic [OFF_W-1:0]  rdOffset,
  input logic [DATA_W-1:0] rdData,
  input logic [CNT_W-1:0]  fifoCount,
  input logic              overflow
);
  // R10: never more entries than slots
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifoCount) <= DEPTH);

  // R6: valid tracks a nonempty queue
  p_valid_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid == (fifoCount != '0));

  // R6: an unread head stays put
  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && !rdReady) |=> ($stable(rdOffset) && $stable(rdData)));

  // R7: the flag is sticky without a clear
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovfClr) |=> overflow);

  // R7: the flag only rises from a full queue
  p_ovf_rise_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (int'($past(fifoCount)) == DEPTH));

  // R8: a clear with no possible drop empties the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfClr && int'(fifoCount) != DEPTH) |=> !overflow);

  // R9: the count moves by at most one per edge
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifoCount) == int'($past(fifoCount))) ||
    (int'(fifoCount) == int'($past(fifoCount)) + 1) ||
    (int'(fifoCount) + 1 == int'($past(fifoCount))));
endmodule

bind bus_write_snooper snoop_checker #(
  .DEPTH(DEPTH), .OFF_W(OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) i_snoopChk (
  .clk(clk), .rst_n(rst_n), .ovfClr(ovfClr), .rdReady(rdReady),
  .rdValid(rdValid), .rdOffset(rdOffset), .rdData(rdData),
  .fifoCount(fifoCount), .overflow(overflow)
);

// File: tb/test_bus_write_snooper.sv
module test_bus_write_snooper;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] hostAddr;
  logic [7:0]  hostData;
  logic        hostRwN;
  logic        hostDsN;
  logic [4:0]  cfgBase;
  logic [1:0]  cfgSize;
  logic        ovfClr;
  logic        rdReady;
  logic        rdValid;
  logic [16:0] rdOffset;
  logic [7:0]  rdData;
  logic [4:0]  fifoCount;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  logic [24:0] q[$];
  bit expOvf = 1'b0;

  always #4 clk = ~clk;

  bus_write_snooper i_bus_write_snooper (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostData(hostData),
    .hostRwN(hostRwN), .hostDsN(hostDsN), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .ovfClr(ovfClr), .rdReady(rdReady), .rdValid(rdValid), .rdOffset(rdOffset),
    .rdData(rdData), .fifoCount(fifoCount), .overflow(overflow)
  );

  function automatic int winBits(input logic [1:0] sz);
    return (sz == 2'd0) ? 15 : ((sz == 2'd1) ? 16 : 17);
  endfunction

  function automatic bit expHit(input logic [19:0] a, input logic [4:0] base,
                                input logic [1:0] sz);
    int wb = winBits(sz);
    return (32'(a) >> wb) == (32'(base) >> (wb - 15));
  endfunction

  function automatic logic [16:0] expOff(input logic [19:0] a, input logic [1:0] sz);
    int wb = winBits(sz);
    return 17'(32'(a) & ((32'd1 << wb) - 1));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One host bus cycle; the synchronized strobe edge is seen between the
  // second and third edges after the strobe falls.
  task automatic busCycle(input logic [19:0] a, input logic [7:0] d, input bit wr,
                          input bit popAtFall, input bit clrAtFall);
    bit hit;
    bit popNow;
    bit full;
    @(negedge clk) begin hostAddr = a; hostData = d; hostRwN = !wr; end
    @(negedge clk) hostDsN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    popNow = popAtFall && (q.size() > 0);
    if (popNow) begin
      rdReady = 1'b1;
      check("R9 head seen at coincident read", {7'd0, rdOffset, rdData}, {7'd0, q[0]});
    end
    ovfClr = clrAtFall;
    hit  = wr && expHit(a, cfgBase, cfgSize);
    full = (q.size() == DEPTH);
    if (hit && full) expOvf = 1'b1;
    else if (clrAtFall) expOvf = 1'b0;
    if (hit && !full) q.push_back({expOff(a, cfgSize), d});
    if (popNow) void'(q.pop_front());
    @(negedge clk) begin rdReady = 1'b0; ovfClr = 1'b0; end
    repeat (3) @(negedge clk);
    hostDsN = 1'b1;
    @(negedge clk) hostRwN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic drainAll();
    while (q.size() > 0) begin
      @(negedge clk);
      check("R6 head order and valid", {6'd0, rdValid, rdOffset, rdData}, {6'd0, 1'b1, q[0]});
      rdReady = 1'b1;
      @(negedge clk) rdReady = 1'b0;
      void'(q.pop_front());
    end
    check("R6 empty after drain", {31'd0, rdValid}, 32'd0);
  endtask

  task automatic checkState(input string req);
    check({req, " count"}, 32'(fifoCount), 32'(q.size()));
    check({req, " overflow"}, {31'd0, overflow}, {31'd0, expOvf});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; hostAddr = '0; hostData = '0; hostRwN = 1'b1; hostDsN = 1'b1;
    cfgBase = 5'h04; cfgSize = 2'd0; ovfClr = 1'b0; rdReady = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count after reset", 32'(fifoCount), 32'd0);
    check("R1 valid after reset", {31'd0, rdValid}, 32'd0);
    check("R1 overflow after reset", {31'd0, overflow}, 32'd0);

    // R4/R5 32 KB window at 0x20000
    busCycle(20'h27FFF, 8'hA5, 1'b1, 1'b0, 1'b0);
    checkState("R4 32K top byte hit");
    busCycle(20'h28000, 8'h11, 1'b1, 1'b0, 1'b0);
    checkState("R4 32K just past window");
    // R3 read ignored
    busCycle(20'h20010, 8'h22, 1'b0, 1'b0, 1'b0);
    checkState("R3 read not captured");
    // R2 long strobe: busCycle holds the strobe low for several cycles
    busCycle(20'h20001, 8'h33, 1'b1, 1'b0, 1'b0);
    check("R2 one entry per strobe", 32'(fifoCount), 32'd2);
    drainAll();

    // R4 64 KB window, base low bit ignored (0x38000 -> 0x30000)
    cfgSize = 2'd1; cfgBase = 5'h07;
    busCycle(20'h3FFFF, 8'h44, 1'b1, 1'b0, 1'b0);
    busCycle(20'h30001, 8'h55, 1'b1, 1'b0, 1'b0);
    busCycle(20'h40000, 8'h66, 1'b1, 1'b0, 1'b0);
    checkState("R4 64K window");
    drainAll();
    // R4/R5 128 KB via code 3
    cfgSize = 2'd3; cfgBase = 5'h0C;
    busCycle(20'h7FFFF, 8'h77, 1'b1, 1'b0, 1'b0);
    busCycle(20'h5FFFF, 8'h88, 1'b1, 1'b0, 1'b0);
    checkState("R5 128K offset width");
    drainAll();

    // R9 coincident capture and read
    cfgSize = 2'd0; cfgBase = 5'h02;
    busCycle(20'h10100, 8'h01, 1'b1, 1'b0, 1'b0);
    busCycle(20'h10200, 8'h02, 1'b1, 1'b0, 1'b0);
    busCycle(20'h10300, 8'h03, 1'b1, 1'b1, 1'b0);
    check("R9 count kept on push and pop", 32'(fifoCount), 32'd2);
    drainAll();

    // R7 fill then overflow
    for (int i = 0; i < DEPTH; i++) busCycle(20'h10000 + 20'(i), 8'(i + 8'h40), 1'b1, 1'b0, 1'b0);
    checkState("R10 full count");
    busCycle(20'h10FFF, 8'hEE, 1'b1, 1'b0, 1'b0);
    checkState("R7 drop when full");
    drainAll();
    check("R7 overflow sticky after drain", {31'd0, overflow}, 32'd1);
    @(negedge clk) ovfClr = 1'b1;
    @(negedge clk) ovfClr = 1'b0; expOvf = 1'b0;
    check("R8 clear pulse", {31'd0, overflow}, 32'd0);

    // R8 set wins over a coincident clear
    for (int i = 0; i < DEPTH; i++) busCycle(20'h10000 + 20'(i), 8'(i), 1'b1, 1'b0, 1'b0);
    busCycle(20'h12345, 8'h99, 1'b1, 1'b0, 1'b1);
    checkState("R8 set wins over clear");
    drainAll();
    @(negedge clk) ovfClr = 1'b1;
    @(negedge clk) ovfClr = 1'b0; expOvf = 1'b0;

    // Random mix against the queue model
    for (int t = 0; t < 80; t++) begin
      logic [19:0] a;
      int wb;
      cfgSize = 2'($urandom_range(0, 3));
      if (q.size() == 0 && $urandom_range(0, 3) == 0) cfgBase = 5'($urandom);
      wb = winBits(cfgSize);
      a = 20'($urandom);
      if ($urandom_range(0, 3) != 0)
        a = 20'(({cfgBase, 15'h0} & ~((32'd1 << wb) - 1)) | (32'($urandom) & ((32'd1 << wb) - 1)));
      if (q.size() > 0) begin
        cfgSize = cfgSize; // offsets are stored, so changing size is safe
      end
      busCycle(a, 8'($urandom), $urandom_range(0, 3) != 0,
               $urandom_range(0, 4) == 0, 1'b0);
      checkState("R10 random count");
      if (q.size() >= DEPTH - 2 || $urandom_range(0, 5) == 0) drainAll();
    end
    drainAll();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule